// File: doc/BRIEF.md
# Free-Frame Bitmap Allocator

This block keeps a bitmap with one occupancy bit for every physical frame of a paged memory. By default there are 1024 frames of 512 words each. The bitmap is held as 32 words of 32 bits. Frame 0 holds the segment table, so it is marked as used from reset and is never handed out.

The block serves two kinds of request, one at a time, through a valid/ready handshake. A page request asks for one free frame. A page-table request asks for two adjacent free frames, and such a pair may straddle the boundary between two bitmap words. The search walks the bitmap one word per cycle, lowest frame first. It returns the physical base address of the lowest frame that qualifies, or a failure flag. The frames it returns are marked as used in the same step.

A separate mark port lets the translation engine record frames that are already occupied while it loads the initial tables.

Top module: `frame_alloc_top`

## Requirements
- R1: After reset, every frame except frame 0 is free, `req_ready` is 1 and `resp_valid` is 0. Frame 0 is never returned, so a successful `resp_addr` is never 0.
- R2: A request with `req_pair`=0 returns the lowest free frame f. The address is `resp_addr` = f*512: the frame index sits in bits 18:9 and bits 8:0 are zero.
- R3: A request with `req_pair`=1 returns the lowest f for which both f and f+1 are free. This includes f = 32k+31, where the pair spans two bitmap words. Frame 1023 is never the start of a pair.
- R4: The frame returned by a successful request is marked used, and for a pair so is f+1. No later request returns either frame.
- R5: When no frame qualifies, the response has `resp_fail`=1 and `resp_addr`=0, and no bitmap bit changes.
- R6: A `mark_valid` pulse with index `mark_frame` marks that frame as used from the next clock edge. Marking a frame that is already used has no effect.
- R7: A request is taken on an edge where `req_valid` and `req_ready` are both 1, and `req_pair` is sampled on that edge. `req_ready` stays 0 until the response has been given. `resp_valid` is a one-cycle pulse, and `resp_fail` and `resp_addr` are valid during that pulse.
- R8: `resp_valid` rises k+1 clock edges after the accepting edge. Here k is the bitmap word (frame/32) that holds the highest frame allocated. A failed search responds after 32 edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_valid | input | 1 | Allocation request present |
| req_pair | input | 1 | 1: two adjacent frames (page table); 0: one frame (page) |
| req_ready | output | 1 | Block idle and able to take a request |
| resp_valid | output | 1 | One-cycle result strobe |
| resp_fail | output | 1 | No qualifying frame was found |
| resp_addr | output | 19 | Physical base address of the allocation (frame * 512) |
| mark_valid | input | 1 | Mark the frame `mark_frame` as used |
| mark_frame | input | 10 | Frame index to mark |

## Verification
The bitmap cannot be read directly, so a lost or spurious bit shows up only in a later allocation. A bit that never got set lets a frame be returned twice. A bit that was set wrongly makes a higher frame appear, or causes a failure that should not happen. Either shows up on the first request whose search reaches the damaged word. A broken word carry is revealed by the address and also by the latency, because a response one word early or late means the scanner lost track of its position. The scenarios fill the bitmap gradually with marks and allocations, so that each fault is exposed within a few requests.

// File: rtl/frame_alloc_pkg.sv
package frame_alloc_pkg;

  // Controller states of the search engine.
  typedef enum logic [1:0] {
    FA_IDLE = 2'd0,
    FA_SCAN = 2'd1,
    FA_RESP = 2'd2
  } fa_state_e;

endpackage

// File: rtl/fa_rst_sync.sv
module fa_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);

  logic meta_q;

  // Assert asynchronously, release after two rising edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      srst_n <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      srst_n <= meta_q;
    end
  end

endmodule

// File: rtl/fa_word_scan.sv
module fa_word_scan #(
  parameter int WORD_W = 32,
  localparam int BIT_W = $clog2(WORD_W)
) (
  input  logic [WORD_W-1:0] used_word,
  input  logic              carry_free,
  input  logic              pair_mode,
  output logic              hit,
  output logic              straddle,
  output logic [BIT_W-1:0]  pos,
  output logic              top_free
);

  logic [WORD_W-1:0] free_bits;
  logic [WORD_W-1:0] cand;
  logic              inner_hit;

  always_comb begin
    free_bits = ~used_word;
    // Pair mode: bit i is a candidate when frames i and i+1 are both free.
    if (pair_mode) begin
      cand = free_bits & {1'b0, free_bits[WORD_W-1:1]};
    end else begin
      cand = free_bits;
    end
    // A pair that starts at the top bit of the previous word ranks lowest.
    straddle = pair_mode & carry_free & free_bits[0];
    // Priority encoder: a descending loop leaves the lowest set bit.
    inner_hit = 1'b0;
    pos       = '0;
    for (int i = WORD_W - 1; i >= 0; i--) begin
      if (cand[i]) begin
        inner_hit = 1'b1;
        pos       = BIT_W'(i);
      end
    end
    hit      = straddle | inner_hit;
    top_free = free_bits[WORD_W-1];
  end

endmodule

// File: rtl/fa_bitmap_store.sv
module fa_bitmap_store #(
  parameter int NUM_WORDS = 32,
  parameter int WORD_W    = 32,
  localparam int NUM_FRAMES = NUM_WORDS * WORD_W,
  localparam int BIT_W      = $clog2(WORD_W),
  localparam int WIDX_W     = $clog2(NUM_WORDS),
  localparam int FIDX_W     = WIDX_W + BIT_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [WIDX_W-1:0]     rd_idx,
  output logic [WORD_W-1:0]     rd_word,
  input  logic                  alloc_we,
  input  logic [FIDX_W-1:0]     alloc_base,
  input  logic                  alloc_pair,
  input  logic                  mark_we,
  input  logic [FIDX_W-1:0]     mark_frame,
  output logic [NUM_FRAMES-1:0] bits_flat
);

  logic [NUM_WORDS-1:0][WORD_W-1:0] words_q;
  logic [FIDX_W-1:0]                second_frame;

  assign second_frame = alloc_base + FIDX_W'(1);

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic [WORD_W-1:0] set_mask;
    logic [WORD_W-1:0] word_d;
    logic              word_en;

    always_comb begin
      set_mask = '0;
      if (alloc_we && (alloc_base[FIDX_W-1:BIT_W] == WIDX_W'(w))) begin
        set_mask[alloc_base[BIT_W-1:0]] = 1'b1;
      end
      if (alloc_we && alloc_pair && (second_frame[FIDX_W-1:BIT_W] == WIDX_W'(w))) begin
        set_mask[second_frame[BIT_W-1:0]] = 1'b1;
      end
      if (mark_we && (mark_frame[FIDX_W-1:BIT_W] == WIDX_W'(w))) begin
        set_mask[mark_frame[BIT_W-1:0]] = 1'b1;
      end
      word_d  = words_q[w] | set_mask;
      word_en = |set_mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        words_q[w] <= (w == 0) ? WORD_W'(1) : '0;
      end else if (word_en) begin
        words_q[w] <= word_d;
      end
    end
  end

  assign rd_word   = words_q[rd_idx];
  assign bits_flat = words_q;

  // R1: the segment-table frame stays occupied.
  p_frame0_held_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bits_flat[0]);

  // R4: a committed allocation is visible in the bitmap on the next cycle.
  p_alloc_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_we |=> bits_flat[$past(alloc_base)]);

  // R6: a mark pulse sets its frame.
  p_mark_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mark_we |=> bits_flat[$past(mark_frame)]);

endmodule

// File: rtl/fa_ctrl.sv
module fa_ctrl
  import frame_alloc_pkg::*;
#(
  parameter int NUM_WORDS   = 32,
  parameter int WORD_W      = 32,
  parameter int FRAME_WORDS = 512,
  localparam int BIT_W  = $clog2(WORD_W),
  localparam int WIDX_W = $clog2(NUM_WORDS),
  localparam int FIDX_W = WIDX_W + BIT_W,
  localparam int OFS_W  = $clog2(FRAME_WORDS),
  localparam int PA_W   = FIDX_W + OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_pair,
  output logic              req_ready,
  output logic              resp_valid,
  output logic              resp_fail,
  output logic [PA_W-1:0]   resp_addr,
  output logic [WIDX_W-1:0] rd_idx,
  input  logic [WORD_W-1:0] rd_word,
  output logic              alloc_we,
  output logic [FIDX_W-1:0] alloc_base,
  output logic              alloc_pair
);

  localparam logic [WIDX_W-1:0] LAST_IDX = WIDX_W'(NUM_WORDS - 1);

  fa_state_e         state_q, state_d;
  logic [WIDX_W-1:0] idx_q, idx_d;
  logic              carry_q, carry_d;
  logic              pair_q, pair_d;
  logic              fail_q, fail_d;
  logic [FIDX_W-1:0] base_q, base_d;
  logic              scan_en, done_en;

  logic              s_hit, s_straddle, s_top_free;
  logic [BIT_W-1:0]  s_pos;
  logic [FIDX_W-1:0] hit_frame;

  fa_word_scan #(.WORD_W(WORD_W)) i_scan (
    .used_word  (rd_word),
    .carry_free (carry_q),
    .pair_mode  (pair_q),
    .hit        (s_hit),
    .straddle   (s_straddle),
    .pos        (s_pos),
    .top_free   (s_top_free)
  );

  always_comb begin
    if (s_straddle) begin
      hit_frame = {idx_q, BIT_W'(0)} - FIDX_W'(1);
    end else begin
      hit_frame = {idx_q, s_pos};
    end
  end

  // Next-state logic.
  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    carry_d  = carry_q;
    pair_d   = pair_q;
    fail_d   = fail_q;
    base_d   = base_q;
    scan_en  = 1'b0;
    done_en  = 1'b0;
    alloc_we = 1'b0;
    unique case (state_q)
      FA_IDLE: begin
        if (req_valid) begin
          state_d = FA_SCAN;
          idx_d   = '0;
          carry_d = 1'b0;
          pair_d  = req_pair;
          scan_en = 1'b1;
        end
      end
      FA_SCAN: begin
        if (s_hit) begin
          alloc_we = 1'b1;
          base_d   = hit_frame;
          fail_d   = 1'b0;
          done_en  = 1'b1;
          state_d  = FA_RESP;
        end else if (idx_q == LAST_IDX) begin
          base_d  = '0;
          fail_d  = 1'b1;
          done_en = 1'b1;
          state_d = FA_RESP;
        end else begin
          idx_d   = idx_q + WIDX_W'(1);
          carry_d = s_top_free;
          scan_en = 1'b1;
        end
      end
      FA_RESP: begin
        state_d = FA_IDLE;
      end
      default: begin
        state_d = FA_IDLE;
      end
    endcase
  end

  // Registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FA_IDLE;
      idx_q   <= '0;
      carry_q <= 1'b0;
      pair_q  <= 1'b0;
      fail_q  <= 1'b0;
      base_q  <= '0;
    end else begin
      state_q <= state_d;
      if (scan_en) begin
        idx_q   <= idx_d;
        carry_q <= carry_d;
        pair_q  <= pair_d;
      end
      if (done_en) begin
        fail_q <= fail_d;
        base_q <= base_d;
      end
    end
  end

  assign req_ready  = (state_q == FA_IDLE);
  assign resp_valid = (state_q == FA_RESP);
  assign resp_fail  = fail_q;
  assign resp_addr  = fail_q ? '0 : {base_q, OFS_W'(0)};
  assign rd_idx     = idx_q;
  assign alloc_base = hit_frame;
  assign alloc_pair = pair_q;

  // R7: no second request while one is in flight.
  p_busy_not_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R7: the result strobe lasts one cycle.
  p_resp_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);

  // R1: frame 0 is never granted.
  p_no_frame0_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_fail) |-> (resp_addr != '0));

  // R8: failure is reported only once the last word has been examined.
  p_fail_full_scan_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_fail) |-> ($past(idx_q) == LAST_IDX));

endmodule

// File: rtl/frame_alloc_top.sv
module frame_alloc_top #(
  parameter int NUM_WORDS   = 32,
  parameter int WORD_W      = 32,
  parameter int FRAME_WORDS = 512,
  localparam int NUM_FRAMES = NUM_WORDS * WORD_W,
  localparam int BIT_W      = $clog2(WORD_W),
  localparam int WIDX_W     = $clog2(NUM_WORDS),
  localparam int FIDX_W     = WIDX_W + BIT_W,
  localparam int OFS_W      = $clog2(FRAME_WORDS),
  localparam int PA_W       = FIDX_W + OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_pair,
  output logic              req_ready,
  output logic              resp_valid,
  output logic              resp_fail,
  output logic [PA_W-1:0]   resp_addr,
  input  logic              mark_valid,
  input  logic [FIDX_W-1:0] mark_frame
);

  logic                  srst_n;
  logic [WIDX_W-1:0]     rd_idx;
  logic [WORD_W-1:0]     rd_word;
  logic                  alloc_we;
  logic [FIDX_W-1:0]     alloc_base;
  logic                  alloc_pair;
  logic [NUM_FRAMES-1:0] bits_flat;

  fa_rst_sync i_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  fa_bitmap_store #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W)) i_store (
    .clk        (clk),
    .rst_n      (srst_n),
    .rd_idx     (rd_idx),
    .rd_word    (rd_word),
    .alloc_we   (alloc_we),
    .alloc_base (alloc_base),
    .alloc_pair (alloc_pair),
    .mark_we    (mark_valid),
    .mark_frame (mark_frame),
    .bits_flat  (bits_flat)
  );

  fa_ctrl #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W), .FRAME_WORDS(FRAME_WORDS)) i_ctrl (
    .clk        (clk),
    .rst_n      (srst_n),
    .req_valid  (req_valid),
    .req_pair   (req_pair),
    .req_ready  (req_ready),
    .resp_valid (resp_valid),
    .resp_fail  (resp_fail),
    .resp_addr  (resp_addr),
    .rd_idx     (rd_idx),
    .rd_word    (rd_word),
    .alloc_we   (alloc_we),
    .alloc_base (alloc_base),
    .alloc_pair (alloc_pair)
  );

  // R5: a failed search leaves the bitmap untouched.
  p_fail_keeps_bits_r5: assert property (@(posedge clk) disable iff (!srst_n)
    (resp_valid && resp_fail && !$past(mark_valid)) |-> $stable(bits_flat));

endmodule

// File: tb/test_frame_alloc_top.sv
`timescale 1ns/1ps
module test_frame_alloc_top;

  localparam int NF = 1024;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_pair;
  logic        req_ready;
  logic        resp_valid;
  logic        resp_fail;
  logic [18:0] resp_addr;
  logic        mark_valid;
  logic [9:0]  mark_frame;

  frame_alloc_top i_frame_alloc_top (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_pair   (req_pair),
    .req_ready  (req_ready),
    .resp_valid (resp_valid),
    .resp_fail  (resp_fail),
    .resp_addr  (resp_addr),
    .mark_valid (mark_valid),
    .mark_frame (mark_frame)
  );

  typedef struct {
    bit    fail;
    int    addr;
    int    lat;
    int    acc;
    string tag;
  } exp_t;

  exp_t  sb_q[$];
  bit    model_used [NF];
  int    n_checks = 0;
  int    n_fails  = 0;
  int    cyc      = 0;
  bit    finished = 0;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string tag, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  endtask

  // Monitor: pops the expected item when a result strobe appears.
  always @(negedge clk) begin
    if (rst_n && resp_valid) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R7 unexpected response", 1, 0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(resp_fail == e.fail, {e.tag, " fail flag"}, int'(resp_fail), int'(e.fail));
        check(int'(resp_addr) == e.addr, {e.tag, " address"}, int'(resp_addr), e.addr);
        check((cyc - e.acc) == e.lat, {"R8 latency ", e.tag}, cyc - e.acc, e.lat);
      end
    end
  end

  task automatic mark(int f);
    @(negedge clk);
    mark_valid = 1'b1;
    mark_frame = 10'(f);
    model_used[f] = 1'b1;
    @(negedge clk);
    mark_valid = 1'b0;
  endtask

  task automatic mark_range(int lo, int hi);
    for (int f = lo; f <= hi; f++) mark(f);
  endtask

  // Driver: works out the expected result from the model, then issues the request.
  task automatic alloc(bit pair, string tag);
    exp_t e;
    int   found;
    found = -1;
    for (int f = 0; f < NF; f++) begin
      if (found < 0) begin
        if (!pair && !model_used[f]) found = f;
        if (pair && f < NF - 1 && !model_used[f] && !model_used[f+1]) found = f;
      end
    end
    e.tag = tag;
    if (found < 0) begin
      e.fail = 1'b1;
      e.addr = 0;
      e.lat  = 32;
    end else begin
      e.fail = 1'b0;
      e.addr = found * 512;
      e.lat  = ((pair ? found + 1 : found) / 32) + 1;
      model_used[found] = 1'b1;
      if (pair) model_used[found+1] = 1'b1;
    end
    @(negedge clk);
    check(req_ready == 1'b1, "R7 ready before request", int'(req_ready), 1);
    req_valid = 1'b1;
    req_pair  = pair;
    @(negedge clk);
    e.acc     = cyc;
    req_valid = 1'b0;
    req_pair  = ~pair;
    check(req_ready == 1'b0, "R7 busy after accept", int'(req_ready), 0);
    sb_q.push_back(e);
    while (sb_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "watchdog expired", 0, 1);
      summary();
    end
  end

  initial begin
    rst_n      = 1'b0;
    req_valid  = 1'b0;
    req_pair   = 1'b0;
    mark_valid = 1'b0;
    mark_frame = '0;
    for (int f = 0; f < NF; f++) model_used[f] = 1'b0;
    model_used[0] = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state.
    check(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
    check(resp_valid == 1'b0, "R1 no strobe after reset", int'(resp_valid), 0);

    alloc(1'b0, "R1 R2 first page skips frame 0");
    alloc(1'b1, "R3 first pair");
    alloc(1'b0, "R2 R4 next page");
    mark_range(5, 30);
    mark_range(33, 63);
    alloc(1'b1, "R3 pair across word boundary");
    alloc(1'b0, "R4 R6 page after marks");
    mark(64);
    alloc(1'b0, "R6 repeated mark is harmless");
    mark_range(66, 126);
    mark_range(128, 199);
    mark_range(201, 1021);
    alloc(1'b1, "R3 pair at top frames");
    alloc(1'b1, "R5 pair with none left");
    alloc(1'b0, "R5 R4 page after failed pair");
    alloc(1'b0, "R2 last isolated page");
    alloc(1'b0, "R5 page with none left");
    alloc(1'b1, "R5 pair on full map");

    repeat (3) @(negedge clk);
    check(sb_q.size() == 0, "R7 all responses seen", sb_q.size(), 0);
    finished = 1'b1;
    summary();
  end

endmodule